// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block merges a parameterised set of level-sensitive request lines (2 to 32) into a single interrupt line for a processor. Each request line is registered on the system clock. It is then combined with a software-raised request of the same number and gated by a per-line enable. The lowest-numbered line that remains pending wins. The controller captures the winner's number, fetches that line's handler address from an internal 32-word vector table, and raises the processor line. It keeps that one interrupt in service until software writes the end-of-interrupt register. No other request, even one of higher priority, can displace it before then.

Software reaches the controller through a 32-bit classic bus slave with word addresses. When address bit 5 is clear, address bits 2..0 select one of eight registers; address bits 4..3 are ignored there. When address bit 5 is set, the access goes to the vector table entry given by address bits 4..0. The state machine has three states. ST_WAIT looks for an enabled, pending request. ST_FETCH reads the vector table. ST_SERVE holds the line. The transitions are:
- accept: ST_WAIT to ST_FETCH, taken when the enable bit is set and any request is pending.
- load: ST_FETCH to ST_SERVE, always taken.
- ack: ST_SERVE to ST_WAIT, taken on an end-of-interrupt write.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Request lines are registered once before use. A read of offset 1 returns the registered line levels in bits N-1..0. These are the levels before enable gating and without software requests, and the bits above N-1 read zero.
- R2: Among the pending enabled requests, the lowest-numbered one is selected.
- R3: Offset 0 is the control register, with bit 0 the enable and bit 1 the polarity. It reads back as written, and both bits reset to zero.
- R4: A write to offset 2 sets each enable bit where the written word has a one. A write to offset 3 clears each enable bit where the written word has a one. Offset 4 reads the enable bits, which reset to zero. Offsets 2, 3, 6 and 7 read as zero, and bits at or above N are ignored.
- R5: While an interrupt is in service, a read of offset 5 returns the vector table entry indexed by that interrupt's number.
- R6: A write of any value to offset 7 during service ends the service, and the controller then takes the next pending request.
- R7: A write to offset 6 raises a software request for each one bit. That request stays pending until its own interrupt is ended through offset 7, and then it is cleared.
- R8: When address bit 5 is set, reads and writes go to a 32-word table, and address bits 4..0 select the word.
- R9: Every accepted access is acknowledged by a single-cycle ack in the cycle after it is accepted.
- R10: The processor line is active high when the polarity bit is 1 and active low when it is 0. It sits at the inactive level unless the enable bit is set and an interrupt is in service.
- R11: A request is accepted only in ST_WAIT with the enable bit set. A request that arrives during service, even one of higher priority, does not pre-empt the current interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_cyc | input | 1 | Bus cycle valid |
| bus_stb | input | 1 | Bus strobe |
| bus_we | input | 1 | Write enable |
| bus_adr | input | 6 | Word address |
| bus_wdat | input | 32 | Write data |
| bus_rdat | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | Access acknowledge |
| irq_in | input | N_IRQ | Level-sensitive request lines |
| cpu_irq | output | 1 | Processor interrupt line |

## Verification
The bench builds the controller with N_IRQ = 8. This makes a sweep over all 255 nonzero request patterns feasible. For each pattern, the bench computes the expected vector from the lowest set bit and a known table formula, and it checks the raw status against the pattern. The small width also brings the ignored upper enable bits within reach. Directed sequences then cover pre-emption refusal, masking, both polarities, disabling during service, and software requests with and without their enable bit.

// File: rtl/vic_pkg.sv
package vic_pkg;
    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_FETCH = 2'd1,
        ST_SERVE = 2'd2
    } vic_state_e;

    localparam logic [2:0] OFS_CTRL  = 3'd0;
    localparam logic [2:0] OFS_RAW   = 3'd1;
    localparam logic [2:0] OFS_ENSET = 3'd2;
    localparam logic [2:0] OFS_ENCLR = 3'd3;
    localparam logic [2:0] OFS_MASK  = 3'd4;
    localparam logic [2:0] OFS_VEC   = 3'd5;
    localparam logic [2:0] OFS_SWI   = 3'd6;
    localparam logic [2:0] OFS_EOI   = 3'd7;
endpackage

// File: rtl/vic_prio_pick.sv
module vic_prio_pick #(
    parameter int N     = 32,
    parameter int IDX_W = 5
) (
    input  logic [N-1:0]     req,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/vic_vec_ram.sv
module vic_vec_ram #(
    parameter int DW = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_en,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    input  logic          b_en,
    input  logic [AW-1:0] b_addr,
    output logic [DW-1:0] b_rdata
);
    localparam int DEPTH = 2 ** AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (a_en) begin
            if (a_we) begin
                mem[a_addr] <= a_wdata;
            end
            a_rdata <= mem[a_addr];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_rdata <= '0;
        end else if (b_en) begin
            b_rdata <= mem[b_addr];
        end
    end
endmodule

// File: rtl/vic_bus_if.sv
module vic_bus_if #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cyc,
    input  logic          stb,
    input  logic          we,
    input  logic [AW-1:0] adr,
    output logic          ack,
    output logic          take,
    output logic [7:0]    reg_wr,
    output logic          tbl_en,
    output logic          tbl_sel_q
);
    always_comb begin
        take   = cyc && stb && !ack;
        tbl_en = take && adr[AW-1];
        reg_wr = '0;
        if (take && we && !adr[AW-1]) begin
            reg_wr[adr[2:0]] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack       <= 1'b0;
            tbl_sel_q <= 1'b0;
        end else begin
            ack <= take;
            if (take) begin
                tbl_sel_q <= adr[AW-1];
            end
        end
    end

    a_r9_ack_follows_take : assert property (@(posedge clk) disable iff (!rst_n)
        (cyc && stb && !ack) |=> ack);
    a_r9_ack_single_cycle : assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import vic_pkg::*;
#(
    parameter int N_IRQ = 32,
    parameter int DW    = 32,
    parameter int AW    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_cyc,
    input  logic             bus_stb,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_adr,
    input  logic [DW-1:0]    bus_wdat,
    output logic [DW-1:0]    bus_rdat,
    output logic             bus_ack,
    input  logic [N_IRQ-1:0] irq_in,
    output logic             cpu_irq
);
    localparam int IDX_W = AW - 1;

    logic [N_IRQ-1:0] lvl_q, mask_q, swi_q, pend, wd_n;
    logic             en_q, pol_q, take, tbl_en, tbl_sel_q, pick_hit, eoi, line;
    logic [7:0]       reg_wr;
    logic [IDX_W-1:0] cur_q, pick_idx;
    logic [DW-1:0]    rd_q, tbl_rd, vec;
    vic_state_e       st_q, st_d;

    assign wd_n = bus_wdat[N_IRQ-1:0];
    assign pend = (lvl_q | swi_q) & mask_q;
    assign eoi  = reg_wr[OFS_EOI];

    vic_bus_if #(.AW(AW)) u_bus (
        .clk(clk), .rst_n(rst_n), .cyc(bus_cyc), .stb(bus_stb), .we(bus_we),
        .adr(bus_adr), .ack(bus_ack), .take(take), .reg_wr(reg_wr),
        .tbl_en(tbl_en), .tbl_sel_q(tbl_sel_q)
    );

    vic_prio_pick #(.N(N_IRQ), .IDX_W(IDX_W)) u_pick (
        .req(pend), .hit(pick_hit), .idx(pick_idx)
    );

    vic_vec_ram #(.DW(DW), .AW(IDX_W)) u_tbl (
        .clk(clk), .rst_n(rst_n),
        .a_en(tbl_en), .a_we(bus_we), .a_addr(bus_adr[IDX_W-1:0]),
        .a_wdata(bus_wdat), .a_rdata(tbl_rd),
        .b_en(st_q == ST_FETCH), .b_addr(cur_q), .b_rdata(vec)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_WAIT;
            cur_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_WAIT && en_q && pick_hit) begin
                cur_q <= pick_idx;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_WAIT:  if (en_q && pick_hit) st_d = ST_FETCH;
            ST_FETCH: st_d = ST_SERVE;
            ST_SERVE: if (eoi) st_d = ST_WAIT;
            default:  st_d = ST_WAIT;
        endcase
    end

    // outputs
    always_comb begin
        line    = (st_q == ST_SERVE) && en_q;
        cpu_irq = pol_q ? line : !line;
    end

    // registers seen by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q  <= '0;
            mask_q <= '0;
            swi_q  <= '0;
            en_q   <= 1'b0;
            pol_q  <= 1'b0;
            rd_q   <= '0;
        end else begin
            lvl_q <= irq_in;
            if (reg_wr[OFS_CTRL]) begin
                en_q  <= bus_wdat[0];
                pol_q <= bus_wdat[1];
            end
            if (reg_wr[OFS_ENSET]) mask_q <= mask_q | wd_n;
            if (reg_wr[OFS_ENCLR]) mask_q <= mask_q & ~wd_n;
            if (reg_wr[OFS_SWI]) begin
                swi_q <= swi_q | wd_n;
            end else if (eoi && st_q == ST_SERVE) begin
                swi_q <= swi_q & ~(N_IRQ'(1) << cur_q);
            end
            if (take && !bus_we) begin
                case (bus_adr[2:0])
                    OFS_CTRL: rd_q <= DW'({pol_q, en_q});
                    OFS_RAW:  rd_q <= DW'(lvl_q);
                    OFS_MASK: rd_q <= DW'(mask_q);
                    OFS_VEC:  rd_q <= vec;
                    default:  rd_q <= '0;
                endcase
            end
        end
    end

    assign bus_rdat = tbl_sel_q ? tbl_rd : rd_q;

    a_r11_fetch_after_wait : assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FETCH) |-> ($past(st_q) == ST_WAIT && $past(en_q)));
    a_r2_pick_highest : assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FETCH) |->
            ((($past(pend) >> cur_q) & N_IRQ'(1)) != '0 &&
             ($past(pend) & ((N_IRQ'(1) << cur_q) - N_IRQ'(1))) == '0));
    a_r6_serve_holds : assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SERVE && !eoi) |=> (st_q == ST_SERVE));
    a_r4_set_applies : assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr[OFS_ENSET] |=> ((mask_q & $past(wd_n)) == $past(wd_n)));
endmodule

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
    localparam int CLK_NS = 10;
    localparam int N      = 8;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
    logic [5:0]  adr = '0;
    logic [31:0] wdat = '0, rdat;
    logic        ack, cpu_irq;
    logic [N-1:0] irq = '0;
    int          n_run = 0, n_fail = 0;
    bit          done = 1'b0;

    always #(CLK_NS / 2) clk = ~clk;

    irq_vector_ctrl #(.N_IRQ(N), .DW(32), .AW(6)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_cyc(cyc), .bus_stb(stb), .bus_we(we),
        .bus_adr(adr), .bus_wdat(wdat), .bus_rdat(rdat), .bus_ack(ack),
        .irq_in(irq), .cpu_irq(cpu_irq)
    );

    function automatic logic [31:0] tbl(input int i);
        return 32'hC0DE_0000 + 32'(i) * 32'h0101;
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic xfer(input bit w, input logic [5:0] a, input logic [31:0] d,
                        output logic [31:0] r);
        @(negedge clk);
        cyc = 1'b1; stb = 1'b1; we = w; adr = a; wdat = d;
        @(negedge clk);
        chk(32'(ack), 32'd1, "R9 ack");
        r = rdat;
        cyc = 1'b0; stb = 1'b0; we = 1'b0;
        @(negedge clk);
        chk(32'(ack), 32'd0, "R9 ack drop");
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        logic [31:0] r;
        xfer(1'b1, a, d, r);
    endtask

    task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string req);
        logic [31:0] r;
        xfer(1'b0, a, 32'h0, r);
        chk(r, exp, req);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state: pol=0, en=0 -> inactive level is high
        chk(32'(cpu_irq), 32'd1, "R10 reset line");
        chk(32'(ack), 32'd0, "R9 reset ack");
        rd_chk(6'd0, 32'h0, "R3 ctrl reset");
        rd_chk(6'd4, 32'h0, "R4 mask reset");

        // R8: fill and read back the vector table
        for (int i = 0; i < 32; i++) wr(6'h20 + 6'(i), tbl(i));
        for (int i = 0; i < 32; i++) rd_chk(6'h20 + 6'(i), tbl(i), "R8 table");

        // R4: set/clear enables; upper bits ignored
        wr(6'd2, 32'h0000_00A5);
        rd_chk(6'd4, 32'h0000_00A5, "R4 set");
        wr(6'd2, 32'hFFFF_FF5A);
        rd_chk(6'd4, 32'h0000_00FF, "R4 upper ignored");
        wr(6'd3, 32'h0000_000F);
        rd_chk(6'd4, 32'h0000_00F0, "R4 clear");
        rd_chk(6'd2, 32'h0, "R4 set reads zero");
        rd_chk(6'd3, 32'h0, "R4 clear reads zero");
        rd_chk(6'd6, 32'h0, "R4 swi reads zero");
        rd_chk(6'd7, 32'h0, "R4 eoi reads zero");
        wr(6'd2, 32'hFF);

        // R3: enable, active-high
        wr(6'd0, 32'h3);
        rd_chk(6'd0, 32'h3, "R3 ctrl readback");
        settle();
        chk(32'(cpu_irq), 32'd0, "R10 idle active-high");

        // R1 R2 R5 R6: sweep every nonzero pattern
        for (int p = 1; p < (1 << N); p++) begin
            int lo;
            lo = 0;
            while (((p >> lo) & 1) == 0) lo++;
            irq = N'(p);
            settle();
            chk(32'(cpu_irq), 32'd1, "R10 line active");
            rd_chk(6'd5, tbl(lo), "R2 R5 vector");
            rd_chk(6'd1, 32'(p), "R1 raw status");
            irq = '0;
            wr(6'd7, 32'h0);
            settle();
            chk(32'(cpu_irq), 32'd0, "R6 eoi releases");
        end

        // R11: no pre-emption by higher priority
        irq = 8'h80;
        settle();
        irq = 8'h81;
        settle();
        rd_chk(6'd5, tbl(7), "R11 held");
        chk(32'(cpu_irq), 32'd1, "R11 line held");
        irq = 8'h01;
        wr(6'd7, 32'h0);
        settle();
        rd_chk(6'd5, tbl(0), "R6 next taken");
        irq = '0;
        wr(6'd7, 32'h0);
        settle();

        // R2 with mask: line 0 disabled
        wr(6'd3, 32'h01);
        irq = 8'h03;
        settle();
        rd_chk(6'd5, tbl(1), "R2 masked skip");
        irq = '0;
        wr(6'd7, 32'h0);
        wr(6'd2, 32'h01);
        settle();

        // R10: active-low polarity, then disabled during service
        wr(6'd0, 32'h1);
        settle();
        chk(32'(cpu_irq), 32'd1, "R10 low idle");
        irq = 8'h04;
        settle();
        chk(32'(cpu_irq), 32'd0, "R10 low active");
        rd_chk(6'd5, tbl(2), "R5 vector low pol");
        wr(6'd0, 32'h0);
        settle();
        chk(32'(cpu_irq), 32'd1, "R10 disabled inactive");
        irq = '0;
        wr(6'd7, 32'h0);
        wr(6'd0, 32'h2);
        irq = 8'h10;
        settle();
        chk(32'(cpu_irq), 32'd0, "R11 disabled no accept");
        rd_chk(6'd5, tbl(2), "R11 vector unchanged");
        irq = '0;
        settle();
        wr(6'd0, 32'h3);
        settle();

        // R7: software requests
        wr(6'd6, 32'h20);
        settle();
        chk(32'(cpu_irq), 32'd1, "R7 swi raises");
        rd_chk(6'd5, tbl(5), "R7 swi vector");
        rd_chk(6'd1, 32'h0, "R1 raw excludes swi");
        wr(6'd7, 32'h0);
        settle();
        chk(32'(cpu_irq), 32'd0, "R7 swi cleared");
        wr(6'd3, 32'h40);
        wr(6'd6, 32'h40);
        settle();
        chk(32'(cpu_irq), 32'd0, "R7 swi masked");
        wr(6'd2, 32'h40);
        settle();
        chk(32'(cpu_irq), 32'd1, "R7 swi kept pending");
        rd_chk(6'd5, tbl(6), "R7 swi vector 6");
        wr(6'd7, 32'h0);
        settle();
        chk(32'(cpu_irq), 32'd0, "R7 swi 6 cleared");

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule